// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block fetches outgoing frame data for a network transmitter from a ring of 32-byte descriptors kept in system memory. Software fills descriptors, sets their ownership bit, programs the ring base, and then writes the poll-demand register. The engine then walks the ring from its current pointer. For every descriptor that hardware owns, it reads the buffer bytes and sends them on an 8-bit valid/ready byte stream. It writes the control word back with ownership cleared, then either moves the pointer on by 32 bytes or reloads it from the base. It stops at the first descriptor that software still holds.

Buffers from consecutive descriptors join into one frame. The frame ends with the descriptor that carries the last-segment flag. Ending a frame raises completion bits in a write-1-to-clear status register, and a level interrupt follows the status bits that are enabled. Memory is reached through a single word-wide request/acknowledge master port.

The byte stream follows the usual valid/ready rules. A byte moves on any clock edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the data and the last flag stay frozen, and a stalled output holds up the walk. On the memory side, a request stays asserted with a stable address, direction and write data until `mem_ack` arrives. Read data is taken in the acknowledge cycle.

Top module: `txr_dma_top`

## Requirements
- R1: After reset the base, current pointer, status and interrupt-enable registers read 0, and `irq`, `tx_valid` and `mem_req` are low.
- R2: A write to register index 0 (poll demand) starts a walk, whose first access reads the control word at the current pointer. If bit 31 (hardware owns) of that word is clear, the walk ends after that single access, with no output and the pointer unchanged.
- R3: The descriptor layout is fixed.
  - Offset 0 holds the control word.
  - Offset 4 holds the buffer sizes: buffer-1 size in bits 11:0 and buffer-2 size in bits 27:16. The byte count is their sum.
  - Offset 8 holds the data address. Bytes are read upward from this address, with the byte at address a taken from bits 8*(a mod 4)+7 : 8*(a mod 4) of its word.
- R4: Bytes leave on `tx_data` in memory order, joined across descriptors. `tx_last` marks the final byte of the frame closed by a descriptor with bit 29 (last segment) set. A frame with no bytes produces no output.
- R5: Each processed descriptor's control word is written back to its own address with bit 31 cleared and all other bits unchanged.
- R6: After write-back, the current pointer (register index 2) becomes the base if bit 21 (end of ring) was set, and otherwise advances by 32.
- R7: Writing the base register (index 1) also loads the current pointer with the same value.
- R8: Closing a frame sets status bit 0 (transmit done) and bit 16 (normal summary) of register index 3. Writing that register clears each bit that is 1 in the written value, and the bits stay set otherwise.
- R9: `irq` is high exactly when status ANDed with the interrupt-enable register (index 4) is nonzero.
- R10: Bytes of a frame beyond MAX_FRAME_BYTES (default 8192) are read but dropped. `tx_last` still marks the last byte that was kept.
- R11: A poll demand written while a walk is in progress is remembered. After the walk stops, the engine re-reads the ownership of the descriptor at the current pointer.
- R12: While `tx_valid` is high and `tx_ready` low, `tx_data` and `tx_last` hold. A memory request holds its address, direction and data until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| tx_valid | output | 1 | Frame byte available |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of a frame |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is a poll demand that lands in the middle of a walk, because it must be seen later as a second read of the stopping descriptor. The bench waits for the first memory acknowledge of a walk, writes the poll register again, and counts reads of the stop address.

The other hard cases are the frame-length cap and a zero-length last-segment descriptor that has to close a frame whose bytes were already sent. Directed rings cover both. Random rings vary the buffer offsets, sizes, segment flags and ring position, under random memory latency and random sink back-pressure.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int DESC_BYTES = 32;
  localparam int OWN_BIT    = 31;
  localparam int LS_BIT     = 29;
  localparam int EOR_BIT    = 21;
  localparam int TI_BIT     = 0;
  localparam int NIS_BIT    = 16;
  localparam int SZ_W       = 12;

  typedef enum logic [2:0] {
    RIX_POLL = 3'd0,
    RIX_BASE = 3'd1,
    RIX_CUR  = 3'd2,
    RIX_STAT = 3'd3,
    RIX_IEN  = 3'd4
  } reg_ix_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTL, ST_SIZE, ST_ADDR, ST_FETCH, ST_SHIFT, ST_FLUSH, ST_WB
  } walk_st_e;
endpackage

// File: rtl/txr_regs.sv
module txr_regs
  import txr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              take_poll,
  output logic              poll_pend,
  input  logic              cur_load,
  input  logic [ADDR_W-1:0] cur_next,
  input  logic              set_done,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] cur,
  output logic              irq
);
  localparam logic [31:0] DONE_MASK = (32'h1 << TI_BIT) | (32'h1 << NIS_BIT);

  logic [31:0] stat, ien;
  logic wr_poll, wr_base, wr_stat, wr_ien;

  assign wr_poll = cfg_we && (cfg_addr == RIX_POLL);
  assign wr_base = cfg_we && (cfg_addr == RIX_BASE);
  assign wr_stat = cfg_we && (cfg_addr == RIX_STAT);
  assign wr_ien  = cfg_we && (cfg_addr == RIX_IEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_pend <= 1'b0;
      base      <= '0;
      cur       <= '0;
      stat      <= '0;
      ien       <= '0;
    end else begin
      if (wr_poll)        poll_pend <= 1'b1;
      else if (take_poll) poll_pend <= 1'b0;
      if (wr_base)       base <= cfg_wdata[ADDR_W-1:0];
      if (wr_base)       cur  <= cfg_wdata[ADDR_W-1:0];
      else if (cur_load) cur  <= cur_next;
      stat <= (wr_stat ? (stat & ~cfg_wdata) : stat) | (set_done ? DONE_MASK : 32'h0);
      if (wr_ien) ien <= cfg_wdata;
    end
  end

  always_comb begin
    case (cfg_addr)
      RIX_BASE: cfg_rdata = 32'(base);
      RIX_CUR:  cfg_rdata = 32'(cur);
      RIX_STAT: cfg_rdata = stat;
      RIX_IEN:  cfg_rdata = ien;
      default:  cfg_rdata = 32'h0;
    endcase
  end

  assign irq = |(stat & ien);

  a_r7_base_loads_cur: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_base) |-> (cur == $past(cfg_wdata[ADDR_W-1:0])));
  a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !set_done) |=> ((stat & $past(cfg_wdata)) == 32'h0));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stat && stat[TI_BIT]) |=> stat[TI_BIT]);
  a_r11_poll_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_pend && !take_poll) |=> poll_pend);
endmodule

// File: rtl/txr_byte_out.sv
module txr_byte_out (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] push_data,
  output logic       push_ok,
  input  logic       flush,
  output logic       flush_done,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data,
  output logic       tx_last
);
  logic       hv;
  logic [7:0] hd;
  logic       out_free;

  assign out_free   = !tx_valid || tx_ready;
  assign push_ok    = !hv || out_free;
  assign flush_done = !hv || out_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv       <= 1'b0;
      hd       <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_last  <= 1'b0;
    end else begin
      if (tx_valid && tx_ready) tx_valid <= 1'b0;
      if (push && push_ok) begin
        if (hv) begin
          tx_valid <= 1'b1;
          tx_data  <= hd;
          tx_last  <= 1'b0;
        end
        hv <= 1'b1;
        hd <= push_data;
      end else if (flush && hv && out_free) begin
        tx_valid <= 1'b1;
        tx_data  <= hd;
        tx_last  <= 1'b1;
        hv       <= 1'b0;
      end
    end
  end

  a_r12_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && flush_done) |=> !hv);
endmodule

// File: rtl/txr_walker.sv
module txr_walker
  import txr_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int MAX_FRAME_BYTES = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_pend,
  output logic              take_poll,
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] base,
  output logic              cur_load,
  output logic [ADDR_W-1:0] cur_next,
  output logic              set_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              push,
  output logic [7:0]        push_data,
  input  logic              push_ok,
  output logic              flush,
  input  logic              flush_done
);
  localparam int CNT_W = SZ_W + 1;
  localparam int FC_W  = $clog2(MAX_FRAME_BYTES + 1);
  localparam logic [31:0] OWN_MASK = 32'h1 << OWN_BIT;

  walk_st_e          state;
  logic [31:0]       ctl, word;
  logic [CNT_W-1:0]  rem;
  logic [ADDR_W-1:0] ba;
  logic [FC_W-1:0]   fcnt;
  logic              keep, advance;

  assign keep      = fcnt < FC_W'(MAX_FRAME_BYTES);
  assign advance   = !keep || push_ok;
  assign mem_wdata = ctl & ~OWN_MASK;
  assign push_data = word[{ba[1:0], 3'b000} +: 8];
  assign cur_next  = ctl[EOR_BIT] ? base : cur + ADDR_W'(DESC_BYTES);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    take_poll = 1'b0;
    push      = 1'b0;
    flush     = 1'b0;
    cur_load  = 1'b0;
    set_done  = 1'b0;
    case (state)
      ST_IDLE:  take_poll = poll_pend;
      ST_CTL:   begin mem_req = 1'b1; mem_addr = cur; end
      ST_SIZE:  begin mem_req = 1'b1; mem_addr = cur + ADDR_W'(4); end
      ST_ADDR:  begin mem_req = 1'b1; mem_addr = cur + ADDR_W'(8); end
      ST_FETCH: begin mem_req = 1'b1; mem_addr = {ba[ADDR_W-1:2], 2'b00}; end
      ST_SHIFT: push = keep;
      ST_FLUSH: flush = 1'b1;
      ST_WB: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = cur;
        cur_load = mem_ack;
        set_done = mem_ack && ctl[LS_BIT];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ctl   <= '0;
      word  <= '0;
      rem   <= '0;
      ba    <= '0;
      fcnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (poll_pend) state <= ST_CTL;
        ST_CTL: if (mem_ack) begin
          ctl   <= mem_rdata;
          state <= mem_rdata[OWN_BIT] ? ST_SIZE : ST_IDLE;
        end
        ST_SIZE: if (mem_ack) begin
          rem   <= CNT_W'(mem_rdata[SZ_W-1:0]) + CNT_W'(mem_rdata[16 +: SZ_W]);
          state <= ST_ADDR;
        end
        ST_ADDR: if (mem_ack) begin
          ba <= mem_rdata[ADDR_W-1:0];
          if (rem == '0) state <= ctl[LS_BIT] ? ST_FLUSH : ST_WB;
          else           state <= ST_FETCH;
        end
        ST_FETCH: if (mem_ack) begin
          word  <= mem_rdata;
          state <= ST_SHIFT;
        end
        ST_SHIFT: if (advance) begin
          ba  <= ba + ADDR_W'(1);
          rem <= rem - CNT_W'(1);
          if (keep) fcnt <= fcnt + FC_W'(1);
          if (rem == CNT_W'(1))  state <= ctl[LS_BIT] ? ST_FLUSH : ST_WB;
          else if (ba[1:0] == 2'd3) state <= ST_FETCH;
        end
        ST_FLUSH: if (flush_done) state <= ST_WB;
        ST_WB: if (mem_ack) begin
          if (ctl[LS_BIT]) fcnt <= '0;
          state <= ST_CTL;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
  a_r2_stop_unowned: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CTL && mem_ack && !mem_rdata[OWN_BIT]) |=> !mem_req);
  a_r10_cap: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= FC_W'(MAX_FRAME_BYTES));
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_load && !ctl[EOR_BIT]) |-> (cur_next - cur == ADDR_W'(DESC_BYTES)));
endmodule

// File: rtl/txr_dma_top.sv
module txr_dma_top #(
  parameter int ADDR_W          = 32,
  parameter int MAX_FRAME_BYTES = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              irq
);
  logic              take_poll, poll_pend, cur_load, set_done;
  logic [ADDR_W-1:0] cur_next, base, cur;
  logic              push, push_ok, flush, flush_done;
  logic [7:0]        push_data;

  txr_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .take_poll(take_poll),
    .poll_pend(poll_pend), .cur_load(cur_load), .cur_next(cur_next),
    .set_done(set_done), .base(base), .cur(cur), .irq(irq)
  );

  txr_walker #(.ADDR_W(ADDR_W), .MAX_FRAME_BYTES(MAX_FRAME_BYTES)) walk_i (
    .clk(clk), .rst_n(rst_n), .poll_pend(poll_pend), .take_poll(take_poll),
    .cur(cur), .base(base), .cur_load(cur_load), .cur_next(cur_next),
    .set_done(set_done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .push(push), .push_data(push_data),
    .push_ok(push_ok), .flush(flush), .flush_done(flush_done)
  );

  txr_byte_out out_i (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .push_ok(push_ok), .flush(flush), .flush_done(flush_done),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last)
  );
endmodule

// File: tb/txr_dma_top_tb_top.sv
`timescale 1ns/1ps
module txr_dma_top_tb_top;
  localparam int CAP = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic        mem_req, mem_we, mem_ack, tx_valid, tx_ready, tx_last, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  tx_data;

  always #5 clk = ~clk;

  txr_dma_top #(.ADDR_W(32), .MAX_FRAME_BYTES(CAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .irq(irq)
  );

  logic [31:0] mem [0:1023];
  logic [31:0] mdl [0:1023];
  logic        ack_r = 1'b0;
  logic        rdy_r = 1'b0;
  int          ack_pct = 50;
  int          rdy_pct = 60;
  int          n_chk = 0, n_bad = 0;
  int          acc_cnt = 0, watch_cnt = 0, stall_err = 0, req_err = 0;
  logic [31:0] watch_addr = 32'hFFFF_FFFF;
  logic [8:0]  got_q [$];
  logic [8:0]  exp_q [$];
  logic        p_stall = 1'b0, p_req = 1'b0;
  logic [8:0]  p_tx = '0;
  logic [32:0] p_mem = '0;
  logic        done = 1'b0;

  assign mem_ack   = ack_r;
  assign tx_ready  = rdy_r;
  assign mem_rdata = mem[mem_addr[11:2]];

  always @(posedge clk) begin
    ack_r <= mem_req && !ack_r && (($urandom % 100) < ack_pct);
    rdy_r <= (($urandom % 100) < rdy_pct);
    if (mem_req && ack_r) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else if (mem_addr == watch_addr) watch_cnt <= watch_cnt + 1;
    end
    if (tx_valid && tx_ready) got_q.push_back({tx_last, tx_data});
    if (p_stall && !(tx_valid && p_tx == {tx_last, tx_data})) stall_err <= stall_err + 1;
    if (p_req && !(mem_req && p_mem == {mem_we, mem_addr})) req_err <= req_err + 1;
    p_stall <= tx_valid && !tx_ready;
    p_tx    <= {tx_last, tx_data};
    p_req   <= mem_req && !ack_r;
    p_mem   <= {mem_we, mem_addr};
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 30) begin
      @(negedge clk);
      if (mem_req || tx_valid) q = 0; else q++;
    end
  endtask

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return mdl[a[11:2]][{a[1:0], 3'b000} +: 8];
  endfunction

  // Reference walk over the shadow memory: returns final pointer and done flag.
  task automatic model_walk(input logic [31:0] cur0, input logic [31:0] base,
                            output logic [31:0] cur_o, output bit ti);
    logic [31:0] c = cur0;
    int fc = 0, kept = 0;
    ti = 1'b0;
    for (int g = 0; g < 64; g++) begin
      logic [31:0] ctl, sz, ad;
      int len;
      ctl = mdl[c[11:2]];
      if (!ctl[31]) break;
      sz = mdl[c[11:2] + 10'd1];
      ad = mdl[c[11:2] + 10'd2];
      len = int'(sz[11:0]) + int'(sz[27:16]);
      for (int k = 0; k < len; k++) begin
        if (fc < CAP) begin
          exp_q.push_back({1'b0, mbyte(ad + 32'(k))});
          fc++; kept++;
        end
      end
      if (ctl[29]) begin
        if (kept > 0) exp_q[exp_q.size()-1][8] = 1'b1;
        ti = 1'b1; fc = 0; kept = 0;
      end
      mdl[c[11:2]] = ctl & 32'h7FFF_FFFF;
      c = ctl[21] ? base : c + 32'd32;
    end
    cur_o = c;
  endtask

  task automatic snap();
    for (int i = 0; i < 1024; i++) mdl[i] = mem[i];
    exp_q.delete();
    got_q.delete();
  endtask

  task automatic compare(input string tag);
    logic [31:0] rd;
    bit ok = (got_q.size() == exp_q.size());
    int bad_i = -1;
    if (ok) for (int i = 0; i < exp_q.size(); i++)
      if (got_q[i] !== exp_q[i] && bad_i < 0) begin ok = 1'b0; bad_i = i; end
    chk(ok, "R4", {tag, " stream length/content"}, ok ? 32'(got_q.size())
        : (bad_i < 0 ? 32'(got_q.size()) : 32'(got_q[bad_i])),
        (bad_i < 0) ? 32'(exp_q.size()) : 32'(exp_q[bad_i]));
    ok = 1'b1;
    bad_i = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== mdl[i] && ok) begin ok = 1'b0; bad_i = i; end
    chk(ok, "R5", {tag, " descriptor write-back"}, mem[bad_i], mdl[bad_i]);
    rd = 32'h0;
    cfg_read(3'd0, rd);
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] ctl,
                          input int s1, input int s2, input logic [31:0] ad);
    mem[at[11:2]]        = ctl;
    mem[at[11:2] + 10'd1] = {4'h0, 12'(s2), 4'h0, 12'(s1)};
    mem[at[11:2] + 10'd2] = ad;
  endtask

  task automatic clear_ring();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, ecur;
    bit eti;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
    clear_ring();
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is still asserted and just after
    chk(!irq && !tx_valid && !mem_req, "R1", "outputs in reset", {irq, tx_valid, mem_req}, 0);
    rst_n = 1'b1;
    cfg_read(3'd1, rd); chk(rd == 0, "R1", "base after reset", rd, 0);
    cfg_read(3'd2, rd); chk(rd == 0, "R1", "cur after reset", rd, 0);
    cfg_read(3'd3, rd); chk(rd == 0, "R1", "status after reset", rd, 0);
    cfg_read(3'd4, rd); chk(rd == 0, "R1", "ien after reset", rd, 0);

    // R7 base write loads pointer
    cfg_write(3'd1, 32'h40);
    cfg_read(3'd2, rd); chk(rd == 32'h40, "R7", "cur after base write", rd, 32'h40);

    // R2 poll on unowned descriptor
    snap(); acc_cnt = 0;
    cfg_write(3'd0, 32'h1); wait_quiet();
    chk(acc_cnt == 1, "R2", "accesses on unowned walk", acc_cnt, 1);
    chk(got_q.size() == 0, "R2", "bytes on unowned walk", got_q.size(), 0);
    cfg_read(3'd2, rd); chk(rd == 32'h40, "R2", "cur unchanged", rd, 32'h40);

    // R3/R4/R6 zero-length last segment closes a frame; wrap to base
    put_desc(32'h40, 32'h8000_0A5A, 3, 2, 32'h402);
    put_desc(32'h60, 32'hA020_0000, 0, 0, 32'h500);
    snap(); model_walk(32'h40, 32'h40, ecur, eti);
    cfg_write(3'd0, 32'h1); wait_quiet();
    compare("R3 zero-length last");
    cfg_read(3'd2, rd); chk(rd == ecur, "R6", "cur after wrap", rd, ecur);

    // R8/R9 status and interrupt
    cfg_read(3'd3, rd); chk(rd == 32'h0001_0001, "R8", "done bits set", rd, 32'h0001_0001);
    @(negedge clk); chk(!irq, "R9", "irq with ien=0", irq, 0);
    cfg_write(3'd4, 32'h2); #1 chk(!irq, "R9", "irq with unrelated enable", irq, 0);
    cfg_write(3'd4, 32'h1_0000); #1 chk(irq, "R9", "irq with summary enable", irq, 1);
    cfg_write(3'd3, 32'h1);
    cfg_read(3'd3, rd); chk(rd == 32'h0001_0000, "R8", "w1c bit0", rd, 32'h0001_0000);
    chk(irq, "R9", "irq after partial clear", irq, 1);
    cfg_write(3'd3, 32'h1_0000);
    cfg_read(3'd3, rd); chk(rd == 0, "R8", "w1c bit16", rd, 0);
    chk(!irq, "R9", "irq after full clear", irq, 0);
    cfg_write(3'd4, 32'h0);

    // R10 frame cap across two descriptors
    clear_ring(); cfg_write(3'd1, 32'h80);
    put_desc(32'h80, 32'h8000_0000, 30, 0, 32'h600);
    put_desc(32'hA0, 32'hA020_0000, 20, 10, 32'h700);
    snap(); model_walk(32'h80, 32'h80, ecur, eti);
    cfg_write(3'd0, 32'h1); wait_quiet();
    chk(got_q.size() == CAP, "R10", "bytes kept at cap", got_q.size(), CAP);
    compare("R10 cap");
    cfg_write(3'd3, 32'hFFFF_FFFF);

    // R11 poll during a walk
    clear_ring(); cfg_write(3'd1, 32'h0);
    for (int d = 0; d < 4; d++)
      put_desc(32'(d * 32), 32'hA000_0000, 12, 0, 32'(32'h800 + d * 16));
    snap(); model_walk(32'h0, 32'h0, ecur, eti);
    watch_addr = 32'h80; watch_cnt = 0;
    cfg_write(3'd0, 32'h1);
    while (!mem_ack) @(negedge clk);
    cfg_write(3'd0, 32'h1); wait_quiet();
    chk(watch_cnt == 2, "R11", "reads of stop descriptor", watch_cnt, 2);
    compare("R11 repoll");
    cfg_read(3'd2, rd); chk(rd == ecur, "R6", "cur after advance", rd, ecur);
    watch_addr = 32'hFFFF_FFFF;
    cfg_write(3'd3, 32'hFFFF_FFFF);

    // Random rings: offsets, sizes, segment flags, latency, back-pressure
    for (int t = 0; t < 10; t++) begin
      logic [31:0] b = 32'($urandom % 8) * 32;
      int n = 1 + ($urandom % 6);
      ack_pct = 20 + ($urandom % 80);
      rdy_pct = 10 + ($urandom % 90);
      clear_ring();
      cfg_write(3'd1, b);
      for (int d = 0; d < n; d++) begin
        logic [31:0] c = 32'h8000_0000 | ($urandom & 32'h0000_FFFF);
        if (($urandom % 2) == 0 || d == n - 1) c[29] = 1'b1;
        if (d == n - 1) c[21] = 1'b1;
        put_desc(b + 32'(d * 32), c, $urandom % 12, $urandom % 5,
                 32'h400 + ($urandom % 32'hB00));
      end
      snap(); model_walk(b, b, ecur, eti);
      cfg_write(3'd0, 32'h1); wait_quiet();
      compare("R3 random ring");
      cfg_read(3'd2, rd); chk(rd == ecur, "R6", "random final cur", rd, ecur);
      cfg_read(3'd3, rd); chk(rd == (eti ? 32'h0001_0001 : 32'h0), "R8", "random status", rd,
                               eti ? 32'h0001_0001 : 32'h0);
      cfg_write(3'd3, 32'hFFFF_FFFF);
    end

    chk(stall_err == 0, "R12", "tx held under back-pressure", stall_err, 0);
    chk(req_err == 0, "R12", "memory request held until ack", req_err, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule